// File: doc/BRIEF.md
# Cable-Detect DAC Power Controller

This block sits beside a three-DAC video output stage and decides, once per video frame, whether a display cable is attached to the first and second DACs. At every frame-start strobe it begins an evaluation. Any DAC it had switched off is turned back on, and after a fixed settling window it samples the load-sense comparators. It then publishes a two-bit cable status and, when automatic power-down is enabled, switches off the DACs whose outputs are unloaded until the next frame start.

The output configuration decides which DACs are watched and which DACs go dark. In composite/S-video configuration both sensed DACs are watched. Each one controls its own power: the second one also controls the third DAC, which carries chroma. In component/RGB configuration only the first DAC is watched, and its result decides the power of all three. A DAC that the host has not powered up, or any DAC while the stage sleeps, is never sensed.

Top module: `cable_pwr_ctrl`

## Requirements
- R1: After reset `cable_status` is 2'b11, no automatic power-down flag is set, and `dac_en` equals `host_pwr_up` with every bit cleared while `sleep` is high.
- R2: `cable_status` changes only at the sample point, SETTLE_CYC clock edges after the edge that accepts a frame start. Changes of `sense_i` at any other time have no effect.
- R3: `cable_status` bit 0 reports DAC 1 and bit 1 reports DAC 2. A `sense_i` bit of 1 means a load is present, which gives status 0. A `sense_i` bit of 0 gives status 1.
- R4: With `cfg_component` = 1, DAC 2 is not monitored: `cable_status[1]` keeps its value and `sense_i[1]` has no effect on power.
- R5: A DAC whose `host_pwr_up` bit is 0 is not monitored, and its status bit holds. While `sleep` is 1, frame starts are ignored and all `dac_en` bits are 0.
- R6: While `detect_en` is 0, frame starts are ignored and `cable_status` holds.
- R7: While `auto_pd_en` or `detect_en` is 0, no DAC is automatically powered down, and any existing power-down is released on the next clock edge.
- R8: With `cfg_component` = 0, an unloaded DAC 1 powers down DAC 1 only (`dac_en[0]`).
- R9: With `cfg_component` = 0, an unloaded DAC 2 powers down DAC 2 and DAC 3 (`dac_en[1]`, `dac_en[2]`).
- R10: With `cfg_component` = 1, an unloaded DAC 1 powers down all three DACs.
- R11: One clock after an accepted frame start, every automatic power-down is released for the settling window. The new decision takes effect at the sample point and holds until the next frame start.
- R12: Each `dac_en` bit equals its `host_pwr_up` bit AND NOT `sleep` AND NOT its automatic power-down flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| sense_i | input | 2 | Load-sense comparators for DAC 1 (bit 0) and DAC 2 (bit 1), 1 = load present |
| cfg_component | input | 1 | 0 = composite/S-video, 1 = component/RGB |
| detect_en | input | 1 | Cable detection enable |
| auto_pd_en | input | 1 | Automatic power-down enable |
| host_pwr_up | input | 3 | Host power-up bit per DAC |
| sleep | input | 1 | Stage sleep, forces all DACs off |
| cable_status | output | 2 | Per-DAC cable status, 0 = cable present |
| dac_en | output | 3 | Effective DAC enables |

## Verification
On every cycle the assertions check four things: the status moves only on a sample pulse, the status of DAC 2 stays frozen in component configuration, no enabled DAC lacks its host bit or is on during sleep, and all power-downs are released after an accepted frame start or while auto power-down is off. The mapping from sense values to status bits and to the set of DACs switched off in each configuration is shown only by the bench. The bench sweeps every combination of configuration, enables, host bits and sense values across chained frames. Only the bench scenarios show that sense changes outside the window, and frame starts during sleep, leave the status unchanged.

// File: rtl/cable_pwr_pkg.sv
package cable_pwr_pkg;

    localparam int unsigned NUM_DAC   = 3;
    localparam int unsigned NUM_SENSE = 2;

    typedef struct packed {
        logic [NUM_SENSE-1:0] status;
        logic [NUM_DAC-1:0]   pd_flag;
    } ctrl_state_t;

    typedef enum logic {
        TMR_IDLE   = 1'b0,
        TMR_SETTLE = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/cable_sense_sync.sv
module cable_sense_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cable_settle_timer.sv
module cable_settle_timer
    import cable_pwr_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic fire
);
    localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        tmr_state_e    st;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = (tmr_q.st == TMR_SETTLE) && (tmr_q.cnt == '0);
        if (abort) begin
            tmr_d.st  = TMR_IDLE;
            tmr_d.cnt = '0;
        end else if (start) begin
            tmr_d.st  = TMR_SETTLE;
            tmr_d.cnt = LOAD_VAL;
        end else if (tmr_q.st == TMR_SETTLE) begin
            if (tmr_q.cnt == '0) tmr_d.st  = TMR_IDLE;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.st  <= TMR_IDLE;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = (tmr_q.st == TMR_SETTLE);
endmodule

// File: rtl/cable_pd_decode.sv
module cable_pd_decode
    import cable_pwr_pkg::*;
(
    input  logic [NUM_SENSE-1:0] sense,
    input  logic [NUM_DAC-1:0]   host_pwr_up,
    input  logic                 cfg_component,
    input  logic [NUM_SENSE-1:0] status_old,
    output logic [NUM_SENSE-1:0] status_new,
    output logic [NUM_DAC-1:0]   pd_new
);
    logic [NUM_SENSE-1:0] watched;
    logic [NUM_SENSE-1:0] unloaded;

    always_comb begin
        watched[0] = host_pwr_up[0];
        watched[1] = host_pwr_up[1] & ~cfg_component;
        unloaded   = watched & ~sense;

        for (int i = 0; i < NUM_SENSE; i++) begin
            status_new[i] = watched[i] ? ~sense[i] : status_old[i];
        end

        if (cfg_component) begin
            pd_new = {NUM_DAC{unloaded[0]}};
        end else begin
            pd_new[0] = unloaded[0];
            pd_new[1] = unloaded[1];
            pd_new[2] = unloaded[1];
        end
    end
endmodule

// File: rtl/cable_pwr_ctrl.sv
module cable_pwr_ctrl
    import cable_pwr_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] sense_i,
    input  logic       cfg_component,
    input  logic       detect_en,
    input  logic       auto_pd_en,
    input  logic [2:0] host_pwr_up,
    input  logic       sleep,
    output logic [1:0] cable_status,
    output logic [2:0] dac_en
);
    logic [NUM_SENSE-1:0] sense_sync;
    logic                 accept_start;
    logic                 halt_eval;
    logic                 tmr_busy;
    logic                 tmr_fire;
    logic                 fire_ok;
    logic [NUM_SENSE-1:0] dec_status;
    logic [NUM_DAC-1:0]   dec_pd;

    ctrl_state_t st_d, st_q;

    cable_sense_sync #(
        .WIDTH  (NUM_SENSE),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sense_i),
        .sync_o  (sense_sync)
    );

    assign accept_start = frame_start & detect_en & ~sleep;
    assign halt_eval    = sleep | ~detect_en;

    cable_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept_start),
        .abort (halt_eval),
        .busy  (tmr_busy),
        .fire  (tmr_fire)
    );

    cable_pd_decode u_decode (
        .sense         (sense_sync),
        .host_pwr_up   (host_pwr_up),
        .cfg_component (cfg_component),
        .status_old    (st_q.status),
        .status_new    (dec_status),
        .pd_new        (dec_pd)
    );

    assign fire_ok = tmr_fire & ~halt_eval & ~frame_start;

    always_comb begin
        st_d = st_q;
        if (fire_ok) begin
            st_d.status = dec_status;
        end
        if (halt_eval || !auto_pd_en || accept_start) begin
            st_d.pd_flag = '0;
        end else if (fire_ok) begin
            st_d.pd_flag = dec_pd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status  <= '1;
            st_q.pd_flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cable_status = st_q.status;
    assign dac_en       = host_pwr_up & {NUM_DAC{~sleep}} & ~st_q.pd_flag;
endmodule

// File: rtl/cable_pwr_ctrl_chk.sv
module cable_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       cfg_component,
    input logic       detect_en,
    input logic       auto_pd_en,
    input logic [2:0] host_pwr_up,
    input logic       sleep,
    input logic       fire_ok,
    input logic [1:0] cable_status,
    input logic [2:0] dac_en
);
    // R2
    status_only_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_ok |=> $stable(cable_status));

    // R4
    component_dac2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_ok && cfg_component) |=> $stable(cable_status[1]));

    // R5
    sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (dac_en == 3'b000));

    // R12
    enable_needs_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en & ~host_pwr_up) == 3'b000);

    // R11
    frame_start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && detect_en && !sleep) |=> (sleep || dac_en == host_pwr_up));

    // R7
    no_auto_pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_pd_en || !detect_en) |=> (sleep || dac_en == host_pwr_up));
endmodule

bind cable_pwr_ctrl cable_pwr_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .cfg_component (cfg_component),
    .detect_en     (detect_en),
    .auto_pd_en    (auto_pd_en),
    .host_pwr_up   (host_pwr_up),
    .sleep         (sleep),
    .fire_ok       (fire_ok),
    .cable_status  (cable_status),
    .dac_en        (dac_en)
);

// File: tb/tb_cable_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_cable_pwr_ctrl;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [1:0] sense_i = 2'b00;
    logic       cfg_component = 1'b0;
    logic       detect_en = 1'b0;
    logic       auto_pd_en = 1'b0;
    logic [2:0] host_pwr_up = 3'b000;
    logic       sleep = 1'b0;
    logic [1:0] cable_status;
    logic [2:0] dac_en;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_status;
    logic [2:0] exp_pd;

    always #4 clk = ~clk;

    cable_pwr_ctrl #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sense_i(sense_i),
        .cfg_component(cfg_component), .detect_en(detect_en), .auto_pd_en(auto_pd_en),
        .host_pwr_up(host_pwr_up), .sleep(sleep), .cable_status(cable_status), .dac_en(dac_en)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Bench model of one evaluation (R3, R4, R5, R8, R9, R10)
    task automatic model_frame();
        logic [1:0] w;
        logic [1:0] u;
        if (!detect_en || sleep) begin
            exp_pd = 3'b000;
            return;
        end
        w[0] = host_pwr_up[0];
        w[1] = host_pwr_up[1] && !cfg_component;
        u = w & ~sense_i;
        for (int i = 0; i < 2; i++) if (w[i]) exp_status[i] = ~sense_i[i];
        if (!auto_pd_en) exp_pd = 3'b000;
        else if (cfg_component) exp_pd = {3{u[0]}};
        else exp_pd = {u[1], u[1], u[0]};
    endtask

    task automatic run_frame(input string tag);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        // R11: power-downs released one clock after an accepted start
        if (detect_en && !sleep)
            check({tag, " R11 release"}, {5'd0, dac_en}, {5'd0, host_pwr_up});
        wait_neg(SETTLE + 2);
        model_frame();
        check({tag, " R3 status"}, {6'd0, cable_status}, {6'd0, exp_status});
        check({tag, " R12 dac_en"}, {5'd0, dac_en},
              {5'd0, host_pwr_up & {3{~sleep}} & ~exp_pd});
    endtask

    initial begin
        wait_neg(150000);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_status = 2'b11;
        exp_pd = 3'b000;
        host_pwr_up = 3'b111;
        wait_neg(3);
        // R1 reset state
        check("R1 status", {6'd0, cable_status}, 8'h03);
        check("R1 dac_en", {5'd0, dac_en}, 8'h07);
        rst_n = 1'b1;
        wait_neg(2);
        check("R1 after release", {5'd0, dac_en}, 8'h07);

        // Exhaustive sweep, frames chained so holds and releases are exercised
        for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < 2; a++)
                    for (int h = 0; h < 8; h++)
                        for (int s = 0; s < 4; s++) begin
                            @(negedge clk);
                            cfg_component = c[0];
                            detect_en = d[0];
                            auto_pd_en = a[0];
                            host_pwr_up = h[2:0];
                            sense_i = s[1:0];
                            // R6/R7: with detection off the old power-down is gone next clock
                            if (!detect_en || !auto_pd_en) begin
                                @(negedge clk);
                                exp_pd = 3'b000;
                                check("R7 disable release", {5'd0, dac_en}, {5'd0, host_pwr_up});
                            end
                            run_frame($sformatf("sweep c%0d d%0d a%0d h%0d s%0d R8 R9 R10", c, d, a, h, s));
                        end

        // R2: sense change outside the window leaves status alone
        cfg_component = 1'b0; detect_en = 1'b1; auto_pd_en = 1'b1; host_pwr_up = 3'b111;
        sense_i = 2'b01;
        run_frame("R2 setup");
        sense_i = 2'b10;
        wait_neg(20);
        check("R2 no update between frames", {6'd0, cable_status}, 8'h02);
        check("R2 power held", {5'd0, dac_en}, 8'h01);

        // R4: component mode freezes DAC 2 status
        cfg_component = 1'b1;
        sense_i = 2'b01;
        run_frame("R4 component");
        check("R4 bit1 held", {7'd0, cable_status[1]}, 8'h01);

        // R5: sleep blocks evaluation and forces all off
        cfg_component = 1'b0;
        sense_i = 2'b00;
        sleep = 1'b1;
        @(negedge clk);
        check("R5 sleep off", {5'd0, dac_en}, 8'h00);
        run_frame("R5 sleep frame");
        check("R5 status held asleep", {6'd0, cable_status}, 8'h02);
        sleep = 1'b0;
        @(negedge clk);
        check("R5 wake", {5'd0, dac_en}, 8'h07);

        // R6: detection off ignores frame starts
        detect_en = 1'b0;
        run_frame("R6 detect off");
        check("R6 status held", {6'd0, cable_status}, 8'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule